// File: doc/BRIEF.md
# Accumulator CPU control core

This block is a small multicycle processor built around a single accumulator. It holds a program counter, an opcode register, an argument register, the accumulator and a bank of four general registers. It runs programs out of a 256-word memory of 16-bit words that sits outside the block. Every instruction word carries an opcode in its upper byte and an argument in its lower byte. The 32 opcodes mix immediate, direct memory, register, register-indirect and shift-count arguments. Conditional flow does not use branches. A test instruction whose condition holds steps the program counter once more, so the next instruction is skipped.

The block sits idle and reports itself halted until `start` is pulsed. It then loads the program counter from `entry_addr` and fetches. The fetch drives the counter onto the memory address, and the returned word is latched one cycle later. The counter then steps by one and the instruction executes. Instructions that read a memory operand add one operand cycle after execute. A halt instruction parks the machine until the next `start`. A byte-wide input port and a byte-wide output port carry one-cycle strobes. Shifts, rotates, arithmetic and logic are done by a separate ALU submodule.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, and after it until `start`, `halted` is 1 and `mem_we`, `out_valid` and `in_ack` are 0. A `start` pulse while halted loads the program counter from `entry_addr`, so the next cycle drives `mem_addr` equal to `entry_addr` with `halted` 0.
- R2: The fetched word supplies the opcode in bits 15:8 and the argument in bits 7:0. The program counter then advances by one, so instructions run in address order unless a jump or a skip intervenes.
- R3: The following codes use the argument directly. Code 05 loads the zero-extended argument into the accumulator. Code 06 loads memory[argument]. Code 0E adds memory[argument] to the accumulator. Code 09 writes the accumulator to memory[argument].
- R4: Register-mode codes select general register argument[1:0]; all other argument bits are ignored. The codes are: 04 clear register, 07 load accumulator from register, 0A copy accumulator to register, 0F add register to accumulator, 12 increment register, 13 decrement register, 14 AND into accumulator, 15 OR into accumulator, 17 invert register.
- R5: Indirect codes take the memory address from the low 8 bits of register argument[1:0]. Code 08 loads from it, code 10 adds from it, and code 0B stores the accumulator to it.
- R6: Code 01 sets the program counter to the argument. Code 02 sets it to the low 8 bits of register argument[1:0].
- R7: Four test codes skip the next instruction when their condition is true and fall through otherwise. Code 1B tests for accumulator bit 0 set. Code 1C tests for a nonzero accumulator. Code 1D tests for a nonzero register argument[1:0]. Code 1E tests for accumulator bit 15 set.
- R8: The shift amount K is argument[3:0], and higher argument bits are ignored. Code 18 shifts the accumulator right and code 19 shifts it left, filling vacated bits with zeros. Code 1A rotates it left. K=0 leaves the accumulator unchanged.
- R9: Code 0C loads `in_data` zero-extended into the accumulator and pulses `in_ack` for one cycle. Code 0D drives accumulator bits 7:0 on `out_data` with a one-cycle `out_valid` pulse.
- R10: Code 1F raises `halted`. While halted, no memory write and no port strobe occur. A later `start` resumes at the new entry address, and the accumulator and the general registers keep their values.
- R11: Code 00 does nothing, and any opcode with bits 15:13 nonzero also acts as no operation. Codes 03, 11 and 16 clear, increment and invert the accumulator.
- R12: Memory returns read data one cycle after the address. An instruction takes three cycles, or four when it reads a memory operand (codes 06, 08, 0E, 10). A program running load-direct, add-direct, store-direct and halt from `start` reaches `halted` 14 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at `entry_addr` when halted |
| entry_addr | input | ADDR_W (8) | First instruction address |
| mem_addr | output | ADDR_W (8) | Memory word address |
| mem_wdata | output | DATA_W (16) | Memory write data (accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W (16) | Memory read data, one cycle after address |
| in_data | input | IO_W (8) | Input port byte |
| in_ack | output | 1 | One-cycle pulse when the input byte is taken |
| out_data | output | IO_W (8) | Output port byte |
| out_valid | output | 1 | One-cycle pulse when `out_data` is valid |
| halted | output | 1 | Machine idle or stopped |

## Verification
The assertions assume a memory that returns the word addressed in the previous cycle. They also assume `start` is only pulsed while `halted` is high, and that `in_data` is steady through the execute cycle of an input instruction. The bench models the memory as a registered read port. It loads programs only while the core is halted. It pulses `start` once per program after `halted` is seen, and it holds `in_data` constant for each program. The skip, jump and shift programs place store instructions on the paths that must not run, so a wrong path appears as an unexpected memory write in the scoreboard.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LATCH,
      ST_EXEC,
      ST_OPRD,
      ST_HALT
   } cpu_state_t;

   typedef enum logic [3:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_INC,
      ALU_DEC,
      ALU_AND,
      ALU_OR,
      ALU_NOT,
      ALU_SHR,
      ALU_SHL,
      ALU_ROL
   } alu_op_t;

   localparam int CODE_W = 5;
   typedef logic [CODE_W-1:0] code_t;

   localparam code_t C_NOP      = 5'h00;
   localparam code_t C_JMP      = 5'h01;
   localparam code_t C_JMP_G    = 5'h02;
   localparam code_t C_CLR_A    = 5'h03;
   localparam code_t C_CLR_G    = 5'h04;
   localparam code_t C_LD_IMM   = 5'h05;
   localparam code_t C_LD_MEM   = 5'h06;
   localparam code_t C_LD_G     = 5'h07;
   localparam code_t C_LD_IND   = 5'h08;
   localparam code_t C_ST_MEM   = 5'h09;
   localparam code_t C_ST_G     = 5'h0A;
   localparam code_t C_ST_IND   = 5'h0B;
   localparam code_t C_PORT_IN  = 5'h0C;
   localparam code_t C_PORT_OUT = 5'h0D;
   localparam code_t C_ADD_MEM  = 5'h0E;
   localparam code_t C_ADD_G    = 5'h0F;
   localparam code_t C_ADD_IND  = 5'h10;
   localparam code_t C_INC_A    = 5'h11;
   localparam code_t C_INC_G    = 5'h12;
   localparam code_t C_DEC_G    = 5'h13;
   localparam code_t C_AND_G    = 5'h14;
   localparam code_t C_OR_G     = 5'h15;
   localparam code_t C_INV_A    = 5'h16;
   localparam code_t C_INV_G    = 5'h17;
   localparam code_t C_SHIFT_R  = 5'h18;
   localparam code_t C_SHIFT_L  = 5'h19;
   localparam code_t C_ROT_L    = 5'h1A;
   localparam code_t C_SKIP_ODD = 5'h1B;
   localparam code_t C_SKIP_NZ  = 5'h1C;
   localparam code_t C_SKIP_NZG = 5'h1D;
   localparam code_t C_SKIP_NEG = 5'h1E;
   localparam code_t C_STOP     = 5'h1F;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int SHAMT_W = $clog2(DATA_W)
) (
   input  alu_op_t             op,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   input  logic [SHAMT_W-1:0]  shamt,
   output logic [DATA_W-1:0]   y
);

   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_width
      $error("acc_alu: DATA_W must equal 2**SHAMT_W");
   end

   // logarithmic barrel: stage s moves by 2**s when shamt[s] is set
   logic [DATA_W-1:0] stg [SHAMT_W+1];
   assign stg[0] = a;

   for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
      localparam int D = 1 << s;
      logic [DATA_W-1:0] moved;
      always_comb begin
         case (op)
            ALU_SHR: moved = stg[s] >> D;
            ALU_SHL: moved = stg[s] << D;
            default: moved = {stg[s][DATA_W-D-1:0], stg[s][DATA_W-1:DATA_W-D]};
         endcase
      end
      assign stg[s+1] = shamt[s] ? moved : stg[s];
   end

   always_comb begin
      case (op)
         ALU_PASS: y = b;
         ALU_ADD:  y = a + b;
         ALU_INC:  y = a + DATA_W'(1);
         ALU_DEC:  y = a - DATA_W'(1);
         ALU_AND:  y = a & b;
         ALU_OR:   y = a | b;
         ALU_NOT:  y = ~a;
         ALU_SHR,
         ALU_SHL,
         ALU_ROL:  y = stg[SHAMT_W];
         default:  y = b;
      endcase
   end

   always_comb begin
      if (op == ALU_ROL && shamt == '0) begin
         assert_rot_zero_R8: assert (y == a) else $error("rotate by zero changed the value");
      end
      if (op == ALU_SHR && shamt != '0) begin
         assert_shr_fill_R8: assert (y[DATA_W-1] == 1'b0) else $error("right shift did not fill with zero");
      end
   end

endmodule

// File: rtl/acc_gpr_file.sv
module acc_gpr_file #(
   parameter int DATA_W  = 16,
   parameter int NUM_GPR = 4,
   parameter int IDX_W   = $clog2(NUM_GPR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [DATA_W-1:0]  rd_data
);

   if (NUM_GPR < 2 || (1 << IDX_W) != NUM_GPR) begin : g_bad_count
      $error("acc_gpr_file: NUM_GPR must be a power of two of at least 2");
   end

   logic [NUM_GPR-1:0][DATA_W-1:0] flat;

   for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))
            q <= wr_data;
      end
      assign flat[g] = q;
   end

   assign rd_data = flat[rd_idx];

   assert_gpr_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> flat[$past(wr_idx)] == $past(wr_data))
      else $error("general register write lost");

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 8,
   parameter int IO_W    = 8,
   parameter int NUM_GPR = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  entry_addr,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               mem_we,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic [IO_W-1:0]    in_data,
   output logic               in_ack,
   output logic [IO_W-1:0]    out_data,
   output logic               out_valid,
   output logic               halted
);

   localparam int OPC_W   = DATA_W - ADDR_W;
   localparam int IDX_W   = $clog2(NUM_GPR);
   localparam int SHAMT_W = $clog2(DATA_W);

   // elaboration-time parameter checks
   if (OPC_W < CODE_W) begin : g_bad_opc
      $error("acc_cpu_core: opcode field narrower than the code space");
   end
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_data
      $error("acc_cpu_core: DATA_W must be a power of two");
   end
   if (SHAMT_W > ADDR_W || IDX_W > ADDR_W) begin : g_bad_arg
      $error("acc_cpu_core: argument field too narrow");
   end
   if (IO_W > DATA_W) begin : g_bad_io
      $error("acc_cpu_core: IO_W exceeds DATA_W");
   end

   cpu_state_t         state_q, state_d;
   logic [ADDR_W-1:0]  pc_q, pc_d;
   logic [OPC_W-1:0]   opc_q;
   logic [ADDR_W-1:0]  arg_q;
   logic [DATA_W-1:0]  acc_q;

   // decode: opcodes with bits above the code space set act as no operation
   logic  hi_clear;
   code_t code;

   if (OPC_W > CODE_W) begin : g_wide_opc
      assign hi_clear = ~|opc_q[OPC_W-1:CODE_W];
   end else begin : g_exact_opc
      assign hi_clear = 1'b1;
   end

   assign code = hi_clear ? opc_q[CODE_W-1:0] : C_NOP;

   // general registers
   logic [IDX_W-1:0]   gidx;
   logic [DATA_W-1:0]  gpr_rd;
   logic               gpr_we;
   logic [ADDR_W-1:0]  ind_addr;

   assign gidx     = arg_q[IDX_W-1:0];
   assign ind_addr = gpr_rd[ADDR_W-1:0];

   // ALU hookup
   alu_op_t            alu_op;
   logic [DATA_W-1:0]  alu_a, alu_b, alu_y;
   logic [SHAMT_W-1:0] shamt;
   logic               acc_we;

   assign shamt = arg_q[SHAMT_W-1:0];

   acc_gpr_file #(
      .DATA_W  (DATA_W),
      .NUM_GPR (NUM_GPR),
      .IDX_W   (IDX_W)
   ) u_gpr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (gpr_we),
      .wr_idx  (gidx),
      .wr_data (alu_y),
      .rd_idx  (gidx),
      .rd_data (gpr_rd)
   );

   acc_alu #(
      .DATA_W  (DATA_W),
      .SHAMT_W (SHAMT_W)
   ) u_alu (
      .op    (alu_op),
      .a     (alu_a),
      .b     (alu_b),
      .shamt (shamt),
      .y     (alu_y)
   );

   // instruction classes
   logic is_ind, is_skip, skip_true;

   assign is_ind  = (code == C_LD_IND) || (code == C_ST_IND) || (code == C_ADD_IND);
   assign is_skip = (code == C_SKIP_ODD) || (code == C_SKIP_NZ) ||
                    (code == C_SKIP_NZG) || (code == C_SKIP_NEG);

   always_comb begin
      case (code)
         C_SKIP_ODD: skip_true = acc_q[0];
         C_SKIP_NZ:  skip_true = |acc_q;
         C_SKIP_NZG: skip_true = |gpr_rd;
         C_SKIP_NEG: skip_true = acc_q[DATA_W-1];
         default:    skip_true = 1'b0;
      endcase
   end

   // sequencer and execute decode
   always_comb begin
      state_d = state_q;
      pc_d    = pc_q;
      alu_op  = ALU_PASS;
      alu_a   = acc_q;
      alu_b   = '0;
      acc_we  = 1'b0;
      gpr_we  = 1'b0;
      case (state_q)
         ST_IDLE, ST_HALT: begin
            if (start) begin
               state_d = ST_FETCH;
               pc_d    = entry_addr;
            end
         end
         ST_FETCH: state_d = ST_LATCH;
         ST_LATCH: begin
            state_d = ST_EXEC;
            pc_d    = pc_q + ADDR_W'(1);
         end
         ST_EXEC: begin
            state_d = ST_FETCH;
            case (code)
               C_JMP:      pc_d = arg_q;
               C_JMP_G:    pc_d = ind_addr;
               C_CLR_A:    acc_we = 1'b1;
               C_CLR_G:    gpr_we = 1'b1;
               C_LD_IMM: begin
                  alu_b  = DATA_W'(arg_q);
                  acc_we = 1'b1;
               end
               C_LD_MEM, C_LD_IND, C_ADD_MEM, C_ADD_IND: state_d = ST_OPRD;
               C_LD_G: begin
                  alu_b  = gpr_rd;
                  acc_we = 1'b1;
               end
               C_ST_G: begin
                  alu_b  = acc_q;
                  gpr_we = 1'b1;
               end
               C_PORT_IN: begin
                  alu_b  = DATA_W'(in_data);
                  acc_we = 1'b1;
               end
               C_ADD_G: begin
                  alu_op = ALU_ADD;
                  alu_b  = gpr_rd;
                  acc_we = 1'b1;
               end
               C_INC_A: begin
                  alu_op = ALU_INC;
                  acc_we = 1'b1;
               end
               C_INC_G: begin
                  alu_op = ALU_INC;
                  alu_a  = gpr_rd;
                  gpr_we = 1'b1;
               end
               C_DEC_G: begin
                  alu_op = ALU_DEC;
                  alu_a  = gpr_rd;
                  gpr_we = 1'b1;
               end
               C_AND_G: begin
                  alu_op = ALU_AND;
                  alu_b  = gpr_rd;
                  acc_we = 1'b1;
               end
               C_OR_G: begin
                  alu_op = ALU_OR;
                  alu_b  = gpr_rd;
                  acc_we = 1'b1;
               end
               C_INV_A: begin
                  alu_op = ALU_NOT;
                  acc_we = 1'b1;
               end
               C_INV_G: begin
                  alu_op = ALU_NOT;
                  alu_a  = gpr_rd;
                  gpr_we = 1'b1;
               end
               C_SHIFT_R: begin
                  alu_op = ALU_SHR;
                  acc_we = 1'b1;
               end
               C_SHIFT_L: begin
                  alu_op = ALU_SHL;
                  acc_we = 1'b1;
               end
               C_ROT_L: begin
                  alu_op = ALU_ROL;
                  acc_we = 1'b1;
               end
               C_SKIP_ODD, C_SKIP_NZ, C_SKIP_NZG, C_SKIP_NEG: begin
                  if (skip_true) pc_d = pc_q + ADDR_W'(1);
               end
               C_STOP:     state_d = ST_HALT;
               default:    ;
            endcase
         end
         ST_OPRD: begin
            state_d = ST_FETCH;
            alu_b   = mem_rdata;
            acc_we  = 1'b1;
            alu_op  = (code == C_ADD_MEM || code == C_ADD_IND) ? ALU_ADD : ALU_PASS;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         opc_q   <= '0;
         arg_q   <= '0;
         acc_q   <= '0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         if (state_q == ST_LATCH) begin
            opc_q <= mem_rdata[DATA_W-1:ADDR_W];
            arg_q <= mem_rdata[ADDR_W-1:0];
         end
         if (acc_we) acc_q <= alu_y;
      end
   end

   // memory and port outputs
   always_comb begin
      if (state_q == ST_FETCH) mem_addr = pc_q;
      else if (is_ind)         mem_addr = ind_addr;
      else                     mem_addr = arg_q;
   end

   assign mem_we    = (state_q == ST_EXEC) && (code == C_ST_MEM || code == C_ST_IND);
   assign mem_wdata = acc_q;
   assign out_data  = acc_q[IO_W-1:0];
   assign out_valid = (state_q == ST_EXEC) && (code == C_PORT_OUT);
   assign in_ack    = (state_q == ST_EXEC) && (code == C_PORT_IN);
   assign halted    = (state_q == ST_IDLE) || (state_q == ST_HALT);

   // assertions
   assert_entry_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && start) |=> (!halted && mem_addr == $past(entry_addr)))
      else $error("start did not fetch from the entry address");

   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LATCH) |=> (pc_q == $past(pc_q) + ADDR_W'(1)))
      else $error("program counter did not advance after fetch");

   assert_skip_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && is_skip && skip_true) |=> (pc_q == $past(pc_q) + ADDR_W'(1)))
      else $error("true test did not skip");

   assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, out_valid, in_ack}))
      else $error("more than one strobe in a cycle");

   assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid)
      else $error("output strobe longer than one cycle");

   assert_quiet_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_we && !out_valid && !in_ack))
      else $error("activity while halted");

   assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && !start) |=> halted)
      else $error("left halt without start");

   assert_oprd_follows_exec_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPRD) |-> ($past(state_q) == ST_EXEC))
      else $error("operand cycle not preceded by execute");

endmodule

// File: tb/tb_acc_cpu_core.sv
`timescale 1ns/1ps
module tb_acc_cpu_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  entry_addr = '0;
   logic [7:0]  mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] mem_rdata = '0;
   logic [7:0]  in_data = 8'hA5;
   logic        in_ack;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        halted;

   always #5 clk = ~clk;

   acc_cpu_core dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .entry_addr (entry_addr),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_we     (mem_we),
      .mem_rdata  (mem_rdata),
      .in_data    (in_data),
      .in_ack     (in_ack),
      .out_data   (out_data),
      .out_valid  (out_valid),
      .halted     (halted)
   );

   // memory model with a registered read port
   logic [15:0] mem [256];
   logic        ld_en = 1'b0;
   logic [7:0]  ld_a = '0;
   logic [15:0] ld_d = '0;
   logic [7:0]  ptr = '0;

   always @(posedge clk) begin
      if (ld_en)       mem[ld_a] <= ld_d;
      else if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   // scoreboard: kind 0 = memory write, 1 = output byte, 2 = input taken
   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  addr;
      logic [15:0] data;
   } ev_t;

   ev_t   exp_q[$];
   string req_q[$];
   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;

   function automatic void check(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endfunction

   task automatic expect_ev(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d, input string req);
      exp_q.push_back('{kind: k, addr: a, data: d});
      req_q.push_back(req);
   endtask

   function automatic void observe(logic [1:0] k, logic [7:0] a, logic [15:0] d);
      ev_t   e;
      string r;
      if (exp_q.size() == 0) begin
         total++;
         bad++;
         $display("FAIL R2 unexpected event: actual=%0h expected=none", {k, a, d});
      end else begin
         e = exp_q.pop_front();
         r = req_q.pop_front();
         check(r, "event", {6'd0, k, a, d}, {6'd0, e.kind, e.addr, e.data});
      end
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we)    observe(2'd0, mem_addr, mem_wdata);
         if (out_valid) observe(2'd1, 8'h00, {8'h00, out_data});
         if (in_ack)    observe(2'd2, 8'h00, 16'h0000);
      end
   end

   task automatic org(input logic [7:0] a);
      ptr = a;
   endtask

   task automatic put(input logic [15:0] d);
      @(negedge clk);
      ld_en = 1'b1;
      ld_a  = ptr;
      ld_d  = d;
      @(posedge clk);
      #1 ld_en = 1'b0;
      ptr = ptr + 8'd1;
   endtask

   task automatic launch(input logic [7:0] entry, input string req, output int cyc);
      @(negedge clk);
      entry_addr = entry;
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      @(negedge clk);
      check("R1", "first fetch address", {24'd0, mem_addr}, {24'd0, entry});
      check("R1", "busy after start", {31'd0, halted}, 32'd0);
      cyc = 0;
      while (!halted && cyc < 5000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      check(req, "halted at end", {31'd0, halted}, 32'd1);
      check(req, "all expected events seen", exp_q.size(), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R10 watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int cyc;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1", "halted in reset", {31'd0, halted}, 32'd1);
      check("R1", "no write in reset", {31'd0, mem_we}, 32'd0);
      check("R1", "no strobes in reset", {30'd0, out_valid, in_ack}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "halted after reset", {31'd0, halted}, 32'd1);

      // P1: direct load, add, store, halt (R2 R3 R12)
      org(8'h02); put(16'h0009); put(16'h0005);
      org(8'h06); put(16'h0602); put(16'h0E03); put(16'h0904); put(16'h1F00);
      expect_ev(2'd0, 8'h04, 16'h000E, "R3");
      launch(8'h06, "R3", cyc);
      check("R12", "cycles from start to halted", cyc, 32'd14);
      check("R2", "sequential result in memory", {16'd0, mem[8'h04]}, 32'h000E);

      // P2: register and accumulator ops (R4 R11)
      org(8'h10);
      put(16'h0512); put(16'h0AFD); put(16'h0300); put(16'h094F);
      put(16'h1201); put(16'h0701); put(16'h0F01); put(16'h1301);
      put(16'h1401); put(16'h1501); put(16'h1100); put(16'h1600);
      put(16'h0950); put(16'h1701); put(16'h0701); put(16'h0951);
      put(16'h0401); put(16'h0701); put(16'h0953); put(16'h0511);
      put(16'h2300); put(16'h0000); put(16'h0952); put(16'h1F00);
      expect_ev(2'd0, 8'h4F, 16'h0000, "R11");
      expect_ev(2'd0, 8'h50, 16'hFFEC, "R4");
      expect_ev(2'd0, 8'h51, 16'hFFED, "R4");
      expect_ev(2'd0, 8'h53, 16'h0000, "R4");
      expect_ev(2'd0, 8'h52, 16'h0011, "R11");
      launch(8'h10, "R4", cyc);

      // P3: indirect and jumps (R5 R6)
      org(8'h60); put(16'h1234); put(16'h0100);
      org(8'h30);
      put(16'h0560); put(16'h0A02); put(16'h0802); put(16'h1202);
      put(16'h1002); put(16'h1202); put(16'h0B02); put(16'h0140);
      put(16'h0977);
      org(8'h40); put(16'h0545); put(16'h0A03); put(16'h0203); put(16'h0978);
      org(8'h45); put(16'h1F00);
      expect_ev(2'd0, 8'h62, 16'h1334, "R5");
      launch(8'h30, "R6", cyc);
      check("R5", "indirect store in memory", {16'd0, mem[8'h62]}, 32'h1334);

      // P4: skip tests and shifts (R7 R8)
      org(8'h80);
      put(16'h0581); put(16'h1B00); put(16'h09A0); put(16'h1804);
      put(16'h1B00); put(16'h09A1); put(16'h1C00); put(16'h09A2);
      put(16'h190C); put(16'h1E00); put(16'h09A3); put(16'h1A04);
      put(16'h1E00); put(16'h09A4); put(16'h0400); put(16'h1D00);
      put(16'h09A5); put(16'h1200); put(16'h1D00); put(16'h09A6);
      put(16'h0300); put(16'h1C00); put(16'h09A7); put(16'h05F3);
      put(16'h1A1F); put(16'h09A8); put(16'h1A00); put(16'h09A9);
      put(16'h1F00);
      expect_ev(2'd0, 8'hA1, 16'h0008, "R8");
      expect_ev(2'd0, 8'hA4, 16'h0008, "R8");
      expect_ev(2'd0, 8'hA5, 16'h0008, "R7");
      expect_ev(2'd0, 8'hA7, 16'h0000, "R7");
      expect_ev(2'd0, 8'hA8, 16'h8079, "R8");
      expect_ev(2'd0, 8'hA9, 16'h8079, "R8");
      launch(8'h80, "R7", cyc);

      // P5: input and output ports (R9)
      in_data = 8'hA5;
      org(8'hC0);
      put(16'h0C00); put(16'h0D00); put(16'h1100); put(16'h0D00);
      put(16'h09C8); put(16'h1F00);
      expect_ev(2'd2, 8'h00, 16'h0000, "R9");
      expect_ev(2'd1, 8'h00, 16'h00A5, "R9");
      expect_ev(2'd1, 8'h00, 16'h00A6, "R9");
      expect_ev(2'd0, 8'hC8, 16'h00A6, "R9");
      launch(8'hC0, "R9", cyc);

      // P6: stays halted, then restarts keeping the accumulator (R10)
      repeat (20) @(negedge clk);
      check("R10", "still halted", {31'd0, halted}, 32'd1);
      expect_ev(2'd1, 8'h00, 16'h00A7, "R10");
      expect_ev(2'd0, 8'hC8, 16'h00A7, "R10");
      launch(8'hC2, "R10", cyc);

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule